// File: doc/BRIEF.md
# Memory Error Capture and Status Register

This block sits next to the single-error-correct / double-error-detect checker of a memory controller. It records the first memory error the checker reports. The checker gives it a one-cycle pulse for a corrected (single-bit) error or for an uncorrectable (multi-bit) error, along with the failing 32-bit address and the 8-bit syndrome. The block keeps the upper address bits, the syndrome and a status flag for the error class. It holds that record until software clears it.

Software reaches the block through one 32-bit register on a simple bus. Reads are always available. Writes come with byte enables. The same register holds three control bits:
- a scrub disable, which drives the scrub-enable signal of the read path;
- an enable that turns a captured single-bit error into a non-maskable interrupt request;
- an enable that turns a captured multi-bit error into a bus-error request.

Both requests are levels. Each one stays high while its status bit and its enable are both set.

Top module: `ecc_err_capture`

## Requirements
- R1: After synchronous reset, the register reads 0x0000_0000, the interrupt and bus-error requests are low, and scrub enable is high.
- R2: When both status bits are 0, a corrected-error pulse sets bit 0 in the next cycle. In the same cycle, bits 30:12 load failing-address bits 30:12 and bits 11:4 load the syndrome.
- R3: When both status bits are 0, an uncorrectable-error pulse sets bit 1 in the next cycle. Address and syndrome load the same way as in R2.
- R4: If both pulses arrive in the same cycle while the record is empty, only bit 1 (multi-bit) is set. Bits 0 and 1 are never both 1.
- R5: While either status bit is 1, further error pulses leave the status, address and syndrome fields unchanged.
- R6: A write with byte-enable bit 0 set that has a 1 in bit 0 or in bit 1 clears both status bits. This re-arms capture. Writing 0 to these bits has no effect.
- R7: Control bits are writable through their byte lanes: bit 31 through byte enable 3, and bits 3 and 2 through byte enable 0. Lanes whose enable is 0 are not changed. Writes to bits 30:4 have no effect.
- R8: Scrub enable is high exactly when bit 31 (scrub disable) reads 0.
- R9: The interrupt request is high exactly when bit 0 and bit 2 (the single-bit interrupt enable) are both 1.
- R10: The bus-error request is high exactly when bit 1 and bit 3 (the multi-bit bus-error enable) are both 1.
- R11: Failing-address bits 31 and 11:0 are not retained. Bits 30:12 of the register show only failing-address bits 30:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_pulse | input | 1 | Corrected (single-bit) error strobe |
| ue_pulse | input | 1 | Uncorrectable (multi-bit) error strobe |
| err_addr | input | 32 | Failing address, valid with either strobe |
| err_syn | input | 8 | Syndrome, valid with either strobe |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Register read value |
| nmi_req | output | 1 | Interrupt request for a captured single-bit error |
| berr_req | output | 1 | Bus-error request for a captured multi-bit error |
| scrub_en | output | 1 | Scrub write-back enable for the read path |

## Verification
The hardest cases to reach from the ports are those where an error pulse and a status-clearing write land in the same cycle, or where both error pulses fire together into an empty record. Random stimulus alone rarely hits these at the right state. The stimulus therefore mixes directed steps with a random stream that is biased toward frequent pulses and frequent writes, with status bits often set in the write data. This places clears right next to, and on the same cycles as, new errors. A cycle-level reference model in the bench predicts the full register value and all three outputs on every cycle.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int REG_W       = 32;
    localparam int ADDR_W      = 32;
    localparam int SYN_W       = 8;
    localparam int LANE_W      = 8;
    localparam int NUM_LANES   = REG_W / LANE_W;

    // Field positions that software decodes.
    localparam int SCRUB_DIS_POS = 31;
    localparam int ADDR_HI_POS   = 30;
    localparam int ADDR_LO_POS   = 12;
    localparam int SYN_HI_POS    = 11;
    localparam int SYN_LO_POS    = 4;
    localparam int BERR_EN_POS   = 3;
    localparam int NMI_EN_POS    = 2;
    localparam int MBE_POS       = 1;
    localparam int SBE_POS       = 0;

    localparam int CAP_ADDR_W = ADDR_HI_POS - ADDR_LO_POS + 1;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_SBE   = 2'b01,
        ST_MBE   = 2'b10
    } err_state_e;

    typedef struct packed {
        logic scrub_dis;
        logic berr_en;
        logic nmi_en;
    } ctl_t;

    typedef struct packed {
        err_state_e             st;
        logic [CAP_ADDR_W-1:0]  addr;
        logic [SYN_W-1:0]       syn;
    } cap_t;

    function automatic int lane_of(input int pos);
        return pos / LANE_W;
    endfunction

    // Multi-bit wins when both strobes coincide.
    function automatic err_state_e classify(input logic ce, input logic ue);
        if (ue)      return ST_MBE;
        else if (ce) return ST_SBE;
        else         return ST_EMPTY;
    endfunction

    function automatic logic [REG_W-1:0] pack_reg(input ctl_t c, input cap_t k);
        logic [REG_W-1:0] r;
        r = '0;
        r[SCRUB_DIS_POS]                = c.scrub_dis;
        r[ADDR_HI_POS:ADDR_LO_POS]      = k.addr;
        r[SYN_HI_POS:SYN_LO_POS]        = k.syn;
        r[BERR_EN_POS]                  = c.berr_en;
        r[NMI_EN_POS]                   = c.nmi_en;
        r[MBE_POS]                      = (k.st == ST_MBE);
        r[SBE_POS]                      = (k.st == ST_SBE);
        return r;
    endfunction

endpackage

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wdata,
    input  logic [NUM_LANES-1:0] be,
    output ctl_t                 ctl,
    output logic                 clr_req
);
    localparam int SD_LANE   = lane_of(SCRUB_DIS_POS);
    localparam int BE_LANE   = lane_of(BERR_EN_POS);
    localparam int NE_LANE   = lane_of(NMI_EN_POS);
    localparam int STAT_LANE = lane_of(SBE_POS);

    logic wr_sd, wr_be, wr_ne;

    always_comb begin
        wr_sd   = wr_en && be[SD_LANE];
        wr_be   = wr_en && be[BE_LANE];
        wr_ne   = wr_en && be[NE_LANE];
        clr_req = wr_en && be[STAT_LANE] && (wdata[SBE_POS] || wdata[MBE_POS]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_sd) ctl.scrub_dis <= wdata[SCRUB_DIS_POS];
            if (wr_be) ctl.berr_en   <= wdata[BERR_EN_POS];
            if (wr_ne) ctl.nmi_en    <= wdata[NMI_EN_POS];
        end
    end
endmodule

// File: rtl/ecc_cap_latch.sv
module ecc_cap_latch
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              ue,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SYN_W-1:0]  syn,
    input  logic              clr,
    output cap_t              cap
);
    logic armed;
    logic take;
    cap_t nxt;

    always_comb begin
        armed = (cap.st == ST_EMPTY);
        take  = armed && (ce || ue);
        nxt   = cap;
        if (take) begin
            nxt.st   = classify(ce, ue);
            nxt.addr = addr[ADDR_HI_POS:ADDR_LO_POS];
            nxt.syn  = syn;
        end else if (clr) begin
            nxt.st   = ST_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap <= '{st: ST_EMPTY, addr: '0, syn: '0};
        else     cap <= nxt;
    end
endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq
    import ecc_cap_pkg::*;
(
    input  ctl_t       ctl,
    input  err_state_e st,
    output logic       nmi,
    output logic       berr,
    output logic       scrub
);
    always_comb begin
        nmi   = ctl.nmi_en  && (st == ST_SBE);
        berr  = ctl.berr_en && (st == ST_MBE);
        scrub = !ctl.scrub_dis;
    end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_pulse,
    input  logic                 ue_pulse,
    input  logic [ADDR_W-1:0]    err_addr,
    input  logic [SYN_W-1:0]     err_syn,
    input  logic                 bus_wr_en,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [NUM_LANES-1:0] bus_be,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 nmi_req,
    output logic                 berr_req,
    output logic                 scrub_en
);
    ctl_t ctl;
    cap_t cap;
    logic clr_req;

    ecc_cap_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr_en),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .ctl     (ctl),
        .clr_req (clr_req)
    );

    ecc_cap_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce_pulse),
        .ue   (ue_pulse),
        .addr (err_addr),
        .syn  (err_syn),
        .clr  (clr_req),
        .cap  (cap)
    );

    ecc_cap_irq u_irq (
        .ctl   (ctl),
        .st    (cap.st),
        .nmi   (nmi_req),
        .berr  (berr_req),
        .scrub (scrub_en)
    );

    assign bus_rdata = pack_reg(ctl, cap);
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        ce_pulse,
    input logic        ue_pulse,
    input logic        bus_wr_en,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_rdata,
    input logic        nmi_req,
    input logic        berr_req,
    input logic        scrub_en
);
    // R4: never both status bits
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_rdata[1:0]) <= 1);

    // R4: coincident pulses into an empty record give multi-bit
    a_r4_mbe_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[1:0] == 2'b00 && ce_pulse && ue_pulse) |=> (bus_rdata[1:0] == 2'b10));

    // R5: held record does not move without a clearing write
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[1:0] != 2'b00 && !(bus_wr_en && bus_be[0] && (bus_wdata[1] || bus_wdata[0])))
        |=> ($stable(bus_rdata[30:4]) && $stable(bus_rdata[1:0])));

    // R2: corrected pulse into an empty record sets only the single-bit flag
    a_r2_sbe_set: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[1:0] == 2'b00 && ce_pulse && !ue_pulse) |=> (bus_rdata[1:0] == 2'b01));

    // R9
    a_r9_nmi_gate: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> (bus_rdata[0] && bus_rdata[2]));

    // R10
    a_r10_berr_gate: assert property (@(posedge clk) disable iff (rst)
        berr_req |-> (bus_rdata[1] && bus_rdata[3]));

    // R8
    a_r8_scrub: assert property (@(posedge clk) disable iff (rst)
        scrub_en != bus_rdata[31]);
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .nmi_req   (nmi_req),
    .berr_req  (berr_req),
    .scrub_en  (scrub_en)
);

// File: tb/ecc_err_capture_test.sv
`timescale 1ns/1ps
module ecc_err_capture_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
    logic [31:0] err_addr = '0;
    logic [7:0]  err_syn = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        nmi_req, berr_req, scrub_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state
    logic        m_sd, m_ben, m_nen;
    logic [1:0]  m_st;
    logic [18:0] m_addr;
    logic [7:0]  m_syn;

    always #4 clk = ~clk;

    ecc_err_capture uut (
        .clk(clk), .rst(rst), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .err_addr(err_addr), .err_syn(err_syn), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .nmi_req(nmi_req), .berr_req(berr_req), .scrub_en(scrub_en)
    );

    function automatic logic [31:0] exp_reg();
        return {m_sd, m_addr, m_syn, m_ben, m_nen, m_st};
    endfunction

    task automatic model_reset();
        m_sd = 0; m_ben = 0; m_nen = 0; m_st = 2'b00; m_addr = '0; m_syn = '0;
    endtask

    task automatic model_step(input logic ce, input logic ue, input logic [31:0] a,
                              input logic [7:0] s, input logic we,
                              input logic [31:0] wd, input logic [3:0] be);
        logic clr;
        clr = we && be[0] && (wd[0] || wd[1]);
        if (m_st == 2'b00 && (ce || ue)) begin
            m_st   = ue ? 2'b10 : 2'b01;
            m_addr = a[30:12];
            m_syn  = s;
        end else if (clr) begin
            m_st = 2'b00;
        end
        if (we && be[3]) m_sd = wd[31];
        if (we && be[0]) begin m_ben = wd[3]; m_nen = wd[2]; end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] er;
        logic en, eb, es;
        er = exp_reg();
        en = m_st[0] && m_nen;
        eb = m_st[1] && m_ben;
        es = !m_sd;
        n_checks++;
        if (bus_rdata !== er || nmi_req !== en || berr_req !== eb || scrub_en !== es) begin
            n_fail++;
            $display("FAIL %s: rdata=%h nmi=%b berr=%b scrub=%b expected rdata=%h nmi=%b berr=%b scrub=%b",
                     tag, bus_rdata, nmi_req, berr_req, scrub_en, er, en, eb, es);
        end
    endtask

    // Called at a falling edge; drives one cycle, returns at the next falling edge.
    task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                        input logic [7:0] s, input logic we,
                        input logic [31:0] wd, input logic [3:0] be, input string tag);
        ce_pulse = ce; ue_pulse = ue; err_addr = a; err_syn = s;
        bus_wr_en = we; bus_wdata = wd; bus_be = be;
        model_step(ce, ue, a, s, we, wd, be);
        @(negedge clk);
        ce_pulse = 0; ue_pulse = 0; bus_wr_en = 0;
        check_all(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 32'h0, 8'h0, 0, 32'h0, 4'h0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1 reset state");
        idle("R1 idle after reset");

        step(0, 0, 0, 0, 1, 32'h0000_0004, 4'b0001, "R7 nmi enable write");
        step(1, 0, 32'hFFFF_F123, 8'h5A, 0, 0, 0, "R2 corrected capture");
        n_checks++;
        if (bus_rdata !== 32'h7FFF_F5A5) begin
            n_fail++;
            $display("FAIL R11 address field: actual=%h expected=%h", bus_rdata, 32'h7FFF_F5A5);
        end
        check_all("R9 nmi asserted");
        step(0, 1, 32'h1234_5678, 8'hC3, 0, 0, 0, "R5 held against later error");
        step(1, 0, 32'h0000_0000, 8'h00, 1, 32'h0000_0004, 4'b0001, "R6 write zero no effect");
        step(0, 0, 0, 0, 1, 32'h0000_0006, 4'b0001, "R6 clear via bit1");
        step(1, 1, 32'h8ABC_DFFF, 8'h81, 0, 0, 0, "R4 both pulses gives multi-bit");
        step(0, 0, 0, 0, 1, 32'h0000_0008, 4'b0001, "R10 berr enable");
        step(0, 0, 0, 0, 1, 32'hFFFF_FFF4, 4'b0000, "R7 no lane enabled ignored");
        step(0, 0, 0, 0, 1, 32'hFFFF_FFF8, 4'b1110, "R8 scrub disable and read-only fields");
        step(0, 0, 0, 0, 1, 32'h0000_0001, 4'b0001, "R6 clear via bit0");
        step(0, 1, 32'h4000_1000, 8'h07, 0, 0, 0, "R3 uncorrectable capture");
        step(1, 0, 32'h0, 8'h0, 1, 32'h0000_0002, 4'b0001, "R6 clear with same-cycle error dropped");
        step(1, 0, 32'h0000_2000, 8'h11, 0, 0, 0, "R2 re-armed capture");
        step(0, 0, 0, 0, 1, 32'h0000_0000, 4'b1000, "R8 scrub re-enabled");

        for (int i = 0; i < 4000; i++) begin
            logic ce, ue, we;
            logic [31:0] wd;
            ce = ($urandom_range(0, 3) == 0);
            ue = ($urandom_range(0, 5) == 0);
            we = ($urandom_range(0, 2) == 0);
            wd = $urandom();
            step(ce, ue, $urandom(), 8'($urandom()), we, wd, 4'($urandom()),
                 "R2/R3/R5/R6/R7/R9/R10 random");
        end

        rst = 1;
        model_reset();
        @(negedge clk);
        rst = 0;
        check_all("R1 reset after traffic");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule